// File: doc/BRIEF.md
# Occupancy-Tagged Processor-State Ring

This block moves whole processor states around a closed ring of four registers. Each register, or slot, holds one wide state word and a flag that marks it as full or empty. A word steps forward one slot per cycle, and only into a slot that is empty. On each hop it passes through a small stand-in transform that takes the place of instruction execution. When a word reaches the last slot, the processor number in its next memory address decides where it goes. If the number is this ring's own, the word goes back to the first slot. Otherwise it is offered on an outbound handshake toward a neighbouring processor.

The first slot is fed by a merge with two sources: the inbound handshake from a remote processor and the local loop-back. When both want the slot, the remote word wins. Several rings can be chained through their inbound and outbound ports so that one state can migrate between processors without software help.

The design is written in a state-machine style:
- Each slot is either `SLOT_EMPTY` or `SLOT_FULL`.
- The merge produces one grant per cycle: `GRANT_IDLE`, `GRANT_REMOTE` or `GRANT_LOOP`.
- The last slot takes one route per cycle:
  - `ROUTE_NONE` when the slot is empty.
  - `ROUTE_HOLD` when a word is blocked.
  - `ROUTE_LOOP` when a word returns to the first slot.
  - `ROUTE_EXIT` when a word leaves on the outbound port.
- Each slot moves EMPTY→FULL when it is filled and FULL→EMPTY when it hands off its word.

Top module: `token_ring`

## Requirements
- R1: After reset every slot is empty: `rx_ready` is 1 and `tx_valid` is 0.
- R2: `rx_ready` is 1 exactly when the first slot is empty. A ring whose slots are all full shows `rx_ready` = 0.
- R3: A word moves to the next slot only when that slot is empty. A blocked word keeps its slot. Words are never lost or reordered along the ring.
- R4: Every slot-to-slot hop adds 1, modulo 2^16, to the counter field in word bits [15:0]. The hop from the third slot into the last slot also adds `ADDR_STEP` (default 0x4000_0000) to the 32-bit next address in word bits [63:32]. All other bits pass through unchanged.
- R5: The target processor number is address bits [31:30], which are word bits [63:62].
  - A last-slot word whose target differs from `LOCAL_ID` (default 0) is offered on `tx`.
  - A last-slot word whose target equals `LOCAL_ID` is copied into the first slot when that slot is empty and `rx_valid` is 0.
- R6: When the first slot is empty and both `rx_valid` and a local loop-back request are present, the remote word is taken and the looping word stays in the last slot.
- R7: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid` stays 1 and `tx_state` is stable. On the edge where both are 1, the word leaves, and `tx_valid` is 0 in the following cycle.
- R8: On an otherwise empty ring, a word accepted at edge e0 reaches the last slot at edge e0+3. Each loop-back pass adds four edges, so a word that needs n passes is offered on `tx` after edge e0+4n−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset; empties every slot |
| rx_valid | input | 1 | A remote state is offered to the first slot |
| rx_state | input | W (256) | Remote state word |
| rx_ready | output | 1 | First slot is empty; the offered word is taken at this edge |
| tx_valid | output | 1 | Last slot holds a word bound for another processor |
| tx_state | output | W (256) | Outbound state word (contents of the last slot) |
| tx_ready | input | 1 | The neighbouring processor's first slot is empty |

## Verification
Every result is due at a fixed edge counted from an acceptance edge e0:
- `rx_ready` falls right after e0.
- A word sits in the last slot after e0+3.
- A looping word re-enters the first slot one edge after it finds that slot free, so it is offered on `tx` after e0+4n−1.
- `tx_valid` drops one edge after the handshake completes.

The bench drives inputs on falling edges and samples on the following falling edge. It counts rising edges from acceptance and compares the count with 4n−1. It computes the expected outbound word by arithmetic on the counter and address fields, using a pass count n taken from the target processor number. In the contention case, remote priority is checked through the order in which the two words appear on `tx`.

// File: rtl/tring_pkg.sv
package tring_pkg;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_e;

    typedef enum logic [1:0] {
        GRANT_IDLE   = 2'd0,
        GRANT_REMOTE = 2'd1,
        GRANT_LOOP   = 2'd2
    } grant_e;

    typedef enum logic [1:0] {
        ROUTE_NONE = 2'd0,
        ROUTE_HOLD = 2'd1,
        ROUTE_LOOP = 2'd2,
        ROUTE_EXIT = 2'd3
    } route_e;

endpackage

// File: rtl/tring_xform.sv
// Stand-in for the execution logic between two slots: bumps the counter
// field, and on one chosen hop also advances the next-address field.
module tring_xform #(
    parameter int              W          = 256,
    parameter int              STAGE      = 0,
    parameter int              CNT_W      = 16,
    parameter int              ADDR_LSB   = 32,
    parameter int              ADDR_W     = 32,
    parameter int              ADDR_STAGE = 2,
    parameter logic [ADDR_W-1:0] ADDR_STEP = 32'h4000_0000
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam logic [CNT_W-1:0] CNT_ONE = 1;

    logic [ADDR_W-1:0] addr_n;

    generate
        if (STAGE == ADDR_STAGE) begin : g_addr_step
            assign addr_n = din[ADDR_LSB +: ADDR_W] + ADDR_STEP;
        end else begin : g_addr_pass
            assign addr_n = din[ADDR_LSB +: ADDR_W];
        end
    endgenerate

    always_comb begin
        dout                     = din;
        dout[CNT_W-1:0]          = din[CNT_W-1:0] + CNT_ONE;
        dout[ADDR_LSB +: ADDR_W] = addr_n;
    end
endmodule

// File: rtl/tring_exit.sv
// Route decision for the word in the last slot.
module tring_exit
    import tring_pkg::*;
#(
    parameter int               PID_W    = 2,
    parameter logic [PID_W-1:0] LOCAL_ID = '0
) (
    input  logic             last_full,
    input  logic [PID_W-1:0] pid,
    input  logic             tx_ready,
    input  logic             entry_free,
    input  logic             rx_valid,
    output logic             is_remote,
    output route_e           route
);
    always_comb begin
        is_remote = (pid != LOCAL_ID);
        route     = ROUTE_NONE;
        unique case ({last_full, is_remote})
            2'b10:   route = (entry_free && !rx_valid) ? ROUTE_LOOP : ROUTE_HOLD;
            2'b11:   route = tx_ready ? ROUTE_EXIT : ROUTE_HOLD;
            default: route = ROUTE_NONE;
        endcase
    end
endmodule

// File: rtl/tring_merge.sv
// Fixed-priority merge into the first slot: remote first, loop-back second.
module tring_merge
    import tring_pkg::*;
(
    input  logic   entry_free,
    input  logic   rx_valid,
    input  logic   loop_req,
    output grant_e grant
);
    always_comb begin
        grant = GRANT_IDLE;
        if (entry_free) begin
            unique case ({rx_valid, loop_req})
                2'b10, 2'b11: grant = GRANT_REMOTE;
                2'b01:        grant = GRANT_LOOP;
                default:      grant = GRANT_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/token_ring.sv
module token_ring
    import tring_pkg::*;
#(
    parameter int                W          = 256,
    parameter int                NSTAGE     = 4,
    parameter int                CNT_W      = 16,
    parameter int                ADDR_LSB   = 32,
    parameter int                ADDR_W     = 32,
    parameter int                PID_W      = 2,
    parameter logic [PID_W-1:0]  LOCAL_ID   = '0,
    parameter int                ADDR_STAGE = 2,
    parameter logic [ADDR_W-1:0] ADDR_STEP  = 32'h4000_0000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rx_valid,
    input  logic [W-1:0] rx_state,
    output logic         rx_ready,
    output logic         tx_valid,
    output logic [W-1:0] tx_state,
    input  logic         tx_ready
);
    localparam int LAST    = NSTAGE - 1;
    localparam int PID_LSB = ADDR_LSB + ADDR_W - PID_W;

    slot_e              slot_q [NSTAGE];
    logic [W-1:0]       word_q [NSTAGE];
    logic [W-1:0]       xf     [LAST];
    logic [LAST-1:0]    adv;
    logic [NSTAGE-1:0]  occ;
    logic [PID_W-1:0]   tail_pid;
    logic               entry_free;
    logic               is_remote;
    logic               loop_req;
    grant_e             grant;
    route_e             route;

    genvar s;
    generate
        for (s = 0; s < NSTAGE; s++) begin : g_occ
            assign occ[s] = (slot_q[s] == SLOT_FULL);
        end
        for (s = 0; s < LAST; s++) begin : g_hop
            tring_xform #(
                .W(W), .STAGE(s), .CNT_W(CNT_W), .ADDR_LSB(ADDR_LSB),
                .ADDR_W(ADDR_W), .ADDR_STAGE(ADDR_STAGE), .ADDR_STEP(ADDR_STEP)
            ) u_xf (
                .din  (word_q[s]),
                .dout (xf[s])
            );
            assign adv[s] = occ[s] && !occ[s+1];
        end
    endgenerate

    assign entry_free = !occ[0];
    assign tail_pid   = word_q[LAST][PID_LSB +: PID_W];
    assign loop_req   = occ[LAST] && !is_remote;

    tring_exit #(.PID_W(PID_W), .LOCAL_ID(LOCAL_ID)) u_exit (
        .last_full  (occ[LAST]),
        .pid        (tail_pid),
        .tx_ready   (tx_ready),
        .entry_free (entry_free),
        .rx_valid   (rx_valid),
        .is_remote  (is_remote),
        .route      (route)
    );

    tring_merge u_merge (
        .entry_free (entry_free),
        .rx_valid   (rx_valid),
        .loop_req   (loop_req),
        .grant      (grant)
    );

    // State register: slot occupancy
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSTAGE; i++) slot_q[i] <= SLOT_EMPTY;
        end else begin
            if (grant != GRANT_IDLE)  slot_q[0] <= SLOT_FULL;
            else if (adv[0])          slot_q[0] <= SLOT_EMPTY;
            for (int i = 1; i < LAST; i++) begin
                if (adv[i-1])         slot_q[i] <= SLOT_FULL;
                else if (adv[i])      slot_q[i] <= SLOT_EMPTY;
            end
            if (adv[LAST-1])          slot_q[LAST] <= SLOT_FULL;
            else if (route == ROUTE_LOOP || route == ROUTE_EXIT)
                                      slot_q[LAST] <= SLOT_EMPTY;
        end
    end

    // Payload registers: no reset needed, qualified by occupancy
    always_ff @(posedge clk) begin
        unique case (grant)
            GRANT_REMOTE: word_q[0] <= rx_state;
            GRANT_LOOP:   word_q[0] <= word_q[LAST];
            default:      ;
        endcase
        for (int i = 1; i < NSTAGE; i++) begin
            if (adv[i-1]) word_q[i] <= xf[i-1];
        end
    end

    // Outputs
    always_comb begin
        rx_ready = entry_free;
        tx_valid = occ[LAST] && is_remote;
        tx_state = word_q[LAST];
    end
endmodule

// File: rtl/tring_checker.sv
module tring_checker #(
    parameter int               W        = 256,
    parameter int               NSTAGE   = 4,
    parameter int               PID_LSB  = 62,
    parameter int               PID_W    = 2,
    parameter logic [PID_W-1:0] LOCAL_ID = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic [W-1:0]      rx_state,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [W-1:0]      tx_state,
    input logic [NSTAGE-1:0] occ,
    input logic [W-1:0]      head_word,
    input logic [W-1:0]      tail_word
);
    localparam int LAST = NSTAGE - 1;

    // R2: a taken word occupies the first slot on the next cycle
    assert_entry_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_ready |=> !rx_ready);

    // R6: remote word lands in the first slot whenever it is taken
    assert_remote_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_ready |=> head_word == $past(rx_state));

    // R5: a local-bound word loops into the empty first slot when no remote offer
    assert_loop_back_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !occ[0] && !rx_valid && occ[LAST] && tail_word[PID_LSB +: PID_W] == LOCAL_ID
        |=> head_word == $past(tail_word) && !occ[LAST]);

    // R7: outbound word held while not accepted
    assert_tx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_state));

    // R7: outbound word gone one cycle after the handshake
    assert_tx_leave_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready |=> !tx_valid);

    // R3: a slot blocked by a full successor keeps its word
    genvar s;
    generate
        for (s = 0; s < LAST; s++) begin : g_blk
            assert_blocked_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
                occ[s] && occ[s+1] |=> occ[s]);
        end
    endgenerate
endmodule

bind token_ring tring_checker #(
    .W(W), .NSTAGE(NSTAGE), .PID_LSB(PID_LSB), .PID_W(PID_W), .LOCAL_ID(LOCAL_ID)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .rx_state  (rx_state),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_state  (tx_state),
    .occ       (occ),
    .head_word (word_q[0]),
    .tail_word (word_q[NSTAGE-1])
);

// File: tb/sim_token_ring.sv
`timescale 1ns/1ps
module sim_token_ring;
    localparam int          W     = 256;
    localparam logic [1:0]  LOCAL = 2'd0;
    localparam logic [31:0] STEP  = 32'h4000_0000;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         rx_valid;
    logic [W-1:0] rx_state;
    logic         rx_ready;
    logic         tx_valid;
    logic [W-1:0] tx_state;
    logic         tx_ready;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    token_ring u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_state(rx_state),
        .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_state(tx_state), .tx_ready(tx_ready)
    );

    task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int passes(input logic [W-1:0] w);
        logic [1:0] nxt;
        nxt = w[63:62] + 2'd1;
        return (nxt == LOCAL) ? 2 : 1;
    endfunction

    function automatic logic [W-1:0] expect_out(input logic [W-1:0] w);
        logic [W-1:0] r;
        int n;
        n = passes(w);
        r = w;
        r[15:0]  = w[15:0] + 16'(3 * n);
        r[63:32] = w[63:32] + 32'(n) * STEP;
        return r;
    endfunction

    function automatic logic [W-1:0] mk(input logic [1:0] pid, input logic [15:0] cnt, input int seed);
        logic [W-1:0] r;
        r = {8{32'h9E37_79B9 ^ 32'(seed * 7919)}};
        r[63:62] = pid;
        r[15:0]  = cnt;
        return r;
    endfunction

    task automatic send(input logic [W-1:0] w);
        @(negedge clk);
        while (!rx_ready) @(negedge clk);
        rx_valid = 1'b1;
        rx_state = w;
        @(posedge clk);
        #1 rx_valid = 1'b0;
        rx_state = '0;
    endtask

    // Called at a point between edges; waits for tx_valid, compares, lets it leave.
    task automatic collect(input logic [W-1:0] exp, input string req);
        int k = 0;
        while (!tx_valid && k < 60) begin
            @(negedge clk);
            k++;
        end
        check(tx_valid && tx_state == exp, req, tx_state, exp);
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] wa, wb;
        logic [W-1:0] bp [4];
        logic [15:0]  cnts [4];
        rst_n = 1'b0; rx_valid = 1'b0; rx_state = '0; tx_ready = 1'b1;
        cnts[0] = 16'h0000; cnts[1] = 16'hFFFF; cnts[2] = 16'h1234; cnts[3] = 16'hFFFD;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(rx_ready == 1'b1, "R1 rx_ready", W'(rx_ready), W'(1));
        check(tx_valid == 1'b0, "R1 tx_valid", W'(tx_valid), W'(0));

        // Sweep: every target id x several counter values (R4, R5, R8)
        for (int p = 0; p < 4; p++) begin
            for (int c = 0; c < 4; c++) begin
                int lat = -1;
                wa = mk(2'(p), cnts[c], p * 4 + c);
                send(wa);
                for (int k = 0; k < 40; k++) begin
                    @(negedge clk);
                    if (tx_valid) begin lat = k; break; end
                end
                check(lat == 4 * passes(wa) - 1, "R8 latency", W'(lat), W'(4 * passes(wa) - 1));
                check(tx_state == expect_out(wa), "R4/R5 outbound word", tx_state, expect_out(wa));
                @(posedge clk);
                @(negedge clk);
                check(tx_valid == 1'b0, "R7 gone after handshake", W'(tx_valid), W'(0));
                check(rx_ready == 1'b1, "R2 ring empty again", W'(rx_ready), W'(1));
            end
        end

        // R6: remote offer collides with a loop-back request
        wa = mk(2'd3, 16'h0100, 101);   // target 3 -> becomes local -> loops once
        wb = mk(2'd1, 16'h0200, 202);   // exits after one pass
        send(wa);                        // accepted at e0
        repeat (3) @(posedge clk);       // e1..e3: wa in last slot
        @(negedge clk);
        check(rx_ready == 1'b1, "R2 entry free before contention", W'(rx_ready), W'(1));
        rx_valid = 1'b1; rx_state = wb;
        @(posedge clk);                  // e4: both want the first slot
        #1 rx_valid = 1'b0; rx_state = '0;
        @(negedge clk);
        check(rx_ready == 1'b0, "R6 first slot taken", W'(rx_ready), W'(0));
        collect(expect_out(wb), "R6 remote word leaves first");
        collect(expect_out(wa), "R6 looping word leaves second");

        // R3/R7: back-pressure fills the ring, then drains in order
        tx_ready = 1'b0;
        for (int i = 0; i < 4; i++) begin
            bp[i] = mk(2'(i % 3), 16'(16'h0F00 + i), 300 + i);
            send(bp[i]);
        end
        repeat (4) @(negedge clk);
        check(rx_ready == 1'b0, "R2 full ring not ready", W'(rx_ready), W'(0));
        for (int h = 0; h < 3; h++) begin
            check(tx_valid == 1'b1, "R7 held valid", W'(tx_valid), W'(1));
            check(tx_state == expect_out(bp[0]), "R7 held word", tx_state, expect_out(bp[0]));
            @(negedge clk);
        end
        tx_ready = 1'b1;
        for (int i = 0; i < 4; i++) collect(expect_out(bp[i]), "R3 order kept");
        check(rx_ready == 1'b1, "R3 ring drained", W'(rx_ready), W'(1));
        check(tx_valid == 1'b0, "R3 nothing left", W'(tx_valid), W'(0));

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule